// File: doc/BRIEF.md
# Linear burst read controller

This block sequences synchronous linear burst reads from a word-addressed memory array that sits behind a read port with one cycle of latency. A host opens a burst by holding chip enable and the address-valid strobe low across a rising clock edge. That edge captures the starting word address, the initial wait selection and the power-saving flag. The controller then waits a programmed number of cycles and streams one word per clock from an internal incrementing address counter. The ready flag tells the host, cycle by cycle, whether the data output holds a valid word.

The stream has gaps, and each one is signalled by ready going low for one cycle. A gap follows every word whose low six address bits are all ones, which marks the end of a 64-word group. With power saving enabled there are also gaps before the first word and before the second word. The counter wraps from the top address to zero without stopping. A burst ends when chip enable is released or reset is asserted. A fresh address-valid strobe abandons the running burst and starts a new one.

The controller is built around a four-state machine. `ST_IDLE` means no burst. `ST_LEAD` counts the initial wait. `ST_STREAM` issues one array read per cycle. `ST_BUBBLE` is a single cycle with no read. The transitions are as follows. A start goes from any state to `ST_LEAD`. Chip enable high goes from any state to `ST_IDLE`. Expiry of the lead count goes from `ST_LEAD` to `ST_STREAM`, or to `ST_BUBBLE` when a gap is due. A group-end word goes from `ST_STREAM` to `ST_BUBBLE`. `ST_BUBBLE` always returns to `ST_STREAM`.

Top module: `burst_read_ctrl`

## Requirements
- R1: After reset, `dout_oe`, `rdy` and `mem_rd` are 0 and `dout` reads all zeros.
- R2: A burst starts at a rising edge where `ce_n` and `adv_n` are both low. With W = 4 + `wait_sel` (`wait_sel` 0..3 gives 4..7 cycles), the word at the latched address appears on `dout` with `rdy` high in the cycle that follows edge W after the start edge. `rdy` is low in every earlier cycle of the burst.
- R3: After the first word, each following cycle presents the word at the next higher address with `rdy` high, unless a gap is due.
- R4: After a word whose address has bits [5:0] all ones is presented, `rdy` is low for exactly one cycle, and then the word at the next address follows.
- R5: The word after the highest address (all address bits ones) is the word at address 0. The usual group-end gap comes between the two.
- R6: Chip enable high ends the burst. `dout_oe` and `rdy` drop in that same cycle. No burst resumes when `ce_n` returns low without a new start.
- R7: A start during a running burst discards it. `rdy` stays low until the new first word, which follows the timing of R2.
- R8: With `psave` high at the start edge, the first word arrives one cycle later than R2 gives. One further `rdy`-low cycle comes before the second word. When the first word also ends a group, a single gap covers both causes.
- R9: `wait_sel` and `psave` are sampled only at the start edge. Changing them during a burst leaves that burst's timing unchanged.
- R10: Whenever `rdy` is high, `dout` equals the array word at the expected address.
- R11: When `dout_oe` is low, `dout` reads zero and `rdy` is low.
- R12: Driving `rst_n` low ends a burst at once. `dout_oe`, `rdy` and `mem_rd` go low without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | ADDR_W | Starting word address, captured at the start edge |
| wait_sel | input | SEL_W | Initial wait selection; total wait is MIN_WAIT + value |
| psave | input | 1 | Power-saving mode; adds the extra first- and second-access cycles |
| mem_rd | output | 1 | Read strobe to the array |
| mem_addr | output | ADDR_W | Read address to the array |
| mem_data | input | DATA_W | Array read data, valid one cycle after the read strobe |
| dout | output | DATA_W | Data to the host; zero while the output is disabled |
| dout_oe | output | 1 | Output enable; high while a burst is active and chip enable is low |
| rdy | output | 1 | High when `dout` holds a valid word |

## Verification
The bench sweeps all four wait selections, each with power saving off and on. Every burst starts a few words below a 64-word boundary, so each run separates the lead count, the power-saving second-access gap and the group-end gap, including the case where two causes coincide. A long burst crossing two boundaries, and a burst starting just below the top address, separate ordinary group ends from the wrap to zero. Midway through bursts the bench changes the wait and power-saving inputs, issues back-to-back restarts, releases chip enable, raises address-valid with chip enable high, and pulses reset. Each expected value comes from the schedule that the bench derives from the start address and the sampled settings.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_STREAM = 2'd2,
        ST_BUBBLE = 2'd3
    } burst_state_t;

endpackage

// File: rtl/burst_lead_timer.sv
module burst_lead_timer #(
    parameter int MIN_WAIT = 4,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] wait_sel,
    input  logic             psave,
    output logic             expired
);
    localparam int MAX_LEAD = MIN_WAIT + (1 << SEL_W) - 1;
    localparam int CNT_W    = $clog2(MAX_LEAD + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Reads are issued one cycle before the word shows, so the lead is W-1 (+1 in power-save).
    always_comb begin
        load_val = CNT_W'(MIN_WAIT - 1) + CNT_W'(wait_sel) + CNT_W'(psave);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    p_lead_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter #(
    parameter int ADDR_W  = 21,
    parameter int GROUP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr,
    output logic              at_group_end
);
    logic [ADDR_W-1:0] ptr_q;

    generate
        if (GROUP_W > ADDR_W) begin : g_bad_cfg
            initial $error("GROUP_W must not exceed ADDR_W");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= start_addr;
        end else if (advance) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr          = ptr_q;
    assign at_group_end = &ptr_q[GROUP_W-1:0];

    p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && (&ptr_q)) |=> (ptr_q == '0));

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         halt,
    input  logic         psave_in,
    input  logic         lead_done,
    input  logic         at_group_end,
    output burst_state_t state,
    output logic         issue
);
    burst_state_t state_q, state_d;
    logic         psave_q, psave_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            psave_q <= 1'b0;
        end else begin
            state_q <= state_d;
            psave_q <= psave_d;
        end
    end

    always_comb begin
        state_d = state_q;
        psave_d = psave_q;
        issue   = 1'b0;
        if (start) begin
            state_d = ST_LEAD;
            psave_d = psave_in;
        end else if (halt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_LEAD: begin
                    if (lead_done) begin
                        issue   = 1'b1;
                        state_d = (at_group_end || psave_q) ? ST_BUBBLE : ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    issue   = 1'b1;
                    state_d = at_group_end ? ST_BUBBLE : ST_STREAM;
                end
                ST_BUBBLE: state_d = ST_STREAM;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign state = state_q;

    p_stop_on_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == ST_IDLE));

    p_restart_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_LEAD && !issue));

    p_ps_second_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD && lead_done && psave_q && !start && !halt)
            |=> (state_q == ST_BUBBLE));

endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
    import burst_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 16,
    parameter int GROUP_W  = 6,
    parameter int SEL_W    = 2,
    parameter int MIN_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SEL_W-1:0]  wait_sel,
    input  logic              psave,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              rdy
);
    burst_state_t state;
    logic         start;
    logic         issue;
    logic         lead_done;
    logic         at_group_end;
    logic         valid_q;
    logic [ADDR_W-1:0] ptr;

    assign start = !ce_n && !adv_n;

    burst_lead_timer #(
        .MIN_WAIT (MIN_WAIT),
        .SEL_W    (SEL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .wait_sel (wait_sel),
        .psave    (psave),
        .expired  (lead_done)
    );

    burst_addr_counter #(
        .ADDR_W  (ADDR_W),
        .GROUP_W (GROUP_W)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (start),
        .start_addr   (addr_in),
        .advance      (issue),
        .ptr          (ptr),
        .at_group_end (at_group_end)
    );

    burst_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .halt         (ce_n),
        .psave_in     (psave),
        .lead_done    (lead_done),
        .at_group_end (at_group_end),
        .state        (state),
        .issue        (issue)
    );

    // Array returns data one cycle after the read; ready tracks it with one flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= issue;
        end
    end

    always_comb begin
        dout_oe  = rst_n && !ce_n && (state != ST_IDLE);
        rdy      = dout_oe && valid_q;
        dout     = dout_oe ? mem_data : '0;
        mem_rd   = rst_n && issue;
        mem_addr = ptr;
    end

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    p_group_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && (&mem_addr[GROUP_W-1:0])) |=> !mem_rd);

    p_ready_has_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !ce_n && adv_n) |=> (rdy || ce_n || !adv_n));

endmodule

// File: tb/burst_read_ctrl_bench.sv
module burst_read_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [1:0]    wait_sel = 2'd0;
    logic          psave = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          rdy;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_read_ctrl u_burst_read_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n),
        .addr_in(addr_in), .wait_sel(wait_sel), .psave(psave),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .dout(dout), .dout_oe(dout_oe), .rdy(rdy)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[15:0] ^ {a[20:16], 11'h5A3};
    endfunction

    // Array model: synchronous read, one cycle latency.
    always @(posedge clk) if (mem_rd) mem_data <= pat(mem_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; leaves at the negedge of the last checked cycle.
    task automatic burst(input logic [AW-1:0] a0, input int wsel, input bit ps,
                         input int ncyc, input bit restart);
        int kn;
        int idx;
        logic [AW-1:0] a;
        bit gap_ps;
        ce_n = 1'b0; adv_n = 1'b0; addr_in = a0;
        wait_sel = 2'(wsel); psave = ps;
        @(posedge clk);
        kn = 4 + wsel + (ps ? 1 : 0);
        a = a0; idx = 0; gap_ps = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            check(dout_oe == 1'b1, "R6", 32'(dout_oe), 1);
            if (k == kn) begin
                check(rdy == 1'b1, idx == 0 ? (ps ? "R8" : (restart ? "R7" : "R2")) :
                      (a == '0 ? "R5" : "R3"), 32'(rdy), 1);
                check(dout == pat(a), "R10", 32'(dout), 32'(pat(a)));
                gap_ps = ps && idx == 0;
                kn += ((&a[5:0]) || gap_ps) ? 2 : 1;
                a = a + 1'b1; idx++;
            end else begin
                check(rdy == 1'b0, idx == 0 ? (restart ? "R7" : "R2") :
                      (gap_ps ? "R8" : "R4"), 32'(rdy), 0);
            end
            if (k == 0) begin
                adv_n = 1'b1;
                wait_sel = 2'(3 - wsel);   // R9: late change must not matter
                psave = !ps;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_oe == 0, "R1", 32'(dout_oe), 0);
        check(rdy == 0, "R1", 32'(rdy), 0);
        check(mem_rd == 0, "R1", 32'(mem_rd), 0);
        check(dout == 0, "R1", 32'(dout), 0);

        // Sweep of wait selections and power-save near a group boundary.
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 2; p++) begin
                burst(21'h00003C + 21'(w), w, p[0], 18, 1'b0);
            end
        end
        // First word at group end with power-save: single merged gap.
        burst(21'h00013F, 1, 1'b1, 12, 1'b0);
        // Long burst over two boundaries.
        burst(21'h0007E0, 0, 1'b0, 150, 1'b0);
        // Wrap at the top of memory.
        burst(21'h1FFFFD, 2, 1'b0, 14, 1'b0);
        // Restart in the middle of a burst (R7).
        burst(21'h000100, 3, 1'b0, 9, 1'b0);
        burst(21'h0A5A00, 0, 1'b0, 10, 1'b1);

        // R6: chip enable high ends the burst.
        ce_n = 1'b1;
        #1;
        check(dout_oe == 0, "R6", 32'(dout_oe), 0);
        check(rdy == 0, "R11", 32'(rdy), 0);
        check(dout == 0, "R11", 32'(dout), 0);
        @(negedge clk);
        adv_n = 1'b0;                       // strobe with ce_n high: no start
        @(negedge clk);
        adv_n = 1'b1; ce_n = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(dout_oe == 0, "R6", 32'(dout_oe), 0);
            check(mem_rd == 0, "R6", 32'(mem_rd), 0);
            check(rdy == 0, "R11", 32'(rdy), 0);
        end

        // R12: reset during a burst.
        burst(21'h000200, 0, 1'b0, 7, 1'b0);
        rst_n = 1'b0;
        #1;
        check(dout_oe == 0, "R12", 32'(dout_oe), 0);
        check(rdy == 0, "R12", 32'(rdy), 0);
        check(mem_rd == 0, "R12", 32'(mem_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(dout_oe == 0, "R12", 32'(dout_oe), 0);
            check(rdy == 0, "R12", 32'(rdy), 0);
        end

        // Burst after reset still works.
        burst(21'h00003F, 3, 1'b0, 14, 1'b0);
        ce_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule